// File: doc/BRIEF.md
# Right Shift and Rotate Executor

This block carries out the one-bit right shift and right rotate instructions of an 8-bit accumulator processor. A sequencer presents an opcode together with up to two operand bytes, the X index register, the accumulator and the carry flag, and pulses a start strobe. The block decodes the operation and the addressing mode. It then either works on the accumulator or performs a read-modify-write on a byte held in a synchronous memory.

When the count of cycles defined for that opcode has run, the block returns the result byte and the new C, N and Z values. It raises a one-cycle completion pulse together with write strobes that tell the surrounding core whether to update the accumulator or the memory. A wider value can be shifted right by chaining instructions. The upper byte is shifted first, and the carry it produces then feeds the rotate of the lower byte.

Top module: `shr_exec`

## Requirements
- R1: Exactly ten opcodes are accepted. Logical shift: 0x4A accumulator, 0x46 zero page, 0x56 zero page+X, 0x4E absolute, 0x5E absolute+X. Rotate: 0x6A accumulator, 0x66 zero page, 0x76 zero page+X, 0x6E absolute, 0x7E absolute+X.
- R2: A logical shift moves each bit one place toward bit 0 and puts 0 into bit 7. The old bit 0 becomes the new carry.
- R3: A rotate moves each bit one place toward bit 0 and puts the incoming carry_i into bit 7. The old bit 0 becomes the new carry.
- R4: With flags_we_o, flag_z_o is 1 exactly when the result byte is zero, and flag_n_o equals result bit 7. These two flags and flag_c_o are the only flag outputs.
- R5: Counting the cycle in which start_i is sampled as cycle 1, done_o is high in cycle 2 for accumulator mode, cycle 5 for zero page, cycle 6 for zero page+X and for absolute, and cycle 7 for absolute+X.
- R6: busy_o is high from cycle 2 through the done_o cycle and is low in the cycle after it.
- R7: Zero page uses address {0x00, op_lo_i}. Zero page+X uses {0x00, (op_lo_i + x_i) mod 256}, so the sum wraps inside page zero.
- R8: Absolute addressing is little-endian, {op_hi_i, op_lo_i}. Absolute+X adds x_i to that 16-bit value, and a carry from the low byte propagates into the high byte.
- R9: A memory-mode instruction issues one read (mem_re_o) in cycle 2. It then issues one write (mem_we_o) of the result to that same address in its done_o cycle.
- R10: Accumulator mode performs no memory access. It presents the result on acc_o with acc_we_o high for the done_o cycle only.
- R11: If start_i arrives with any other opcode, illegal_o pulses for one cycle and busy_o stays low. No accumulator write, flag write or memory write occurs.
- R12: A 16-bit right shift is done as a logical shift of the high byte followed by a rotate of the low byte, with the first carry out fed in as carry_i. Together the two instructions give the 16-bit value shifted right by one.
- R13: start_i is ignored while busy_o is high. The running instruction completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin executing the presented opcode |
| opcode_i | input | 8 | Instruction opcode |
| op_lo_i | input | 8 | First operand byte (address low byte) |
| op_hi_i | input | 8 | Second operand byte (address high byte) |
| x_i | input | 8 | X index register |
| acc_i | input | 8 | Accumulator value |
| carry_i | input | 1 | Incoming carry flag |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Final cycle of the instruction |
| illegal_o | output | 1 | Undefined opcode was started |
| acc_o | output | 8 | Result for the accumulator |
| acc_we_o | output | 1 | Accumulator write strobe |
| flag_c_o | output | 1 | New carry flag |
| flag_n_o | output | 1 | New negative flag |
| flag_z_o | output | 1 | New zero flag |
| flags_we_o | output | 1 | Flag write strobe |
| mem_addr_o | output | 16 | Memory byte address |
| mem_re_o | output | 1 | Memory read request, data returned next cycle |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 8 | Memory read data |

## Verification
Each addressing mode is run and its done_o cycle is compared with the required count. An off-by-one sequencer would finish a cycle early or late. The zero page+X case uses a base and index whose sum exceeds 0xFF. A design that carried into the high byte would touch page one instead of wrapping. The absolute+X case crosses a page boundary, which exposes a design that dropped the high-byte carry. Fill-bit cases push both 0 and 1 into bit 7 to separate shift from rotate. The carry chain across two instructions produces a wrong 16-bit value if either fill or carry-out is swapped. An undefined opcode, and a start pulse during a busy instruction, must leave memory, the accumulator strobe and the timing untouched.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;
  localparam int CW = 3;

  typedef enum logic [2:0] {
    AM_ACC, AM_ZP, AM_ZPX, AM_ABS, AM_ABSX
  } amode_e;

  typedef struct packed {
    logic   valid;
    logic   rot;
    amode_e mode;
  } dec_t;

  function automatic logic [CW-1:0] cycles_of(amode_e m);
    case (m)
      AM_ACC:  return CW'(2);
      AM_ZP:   return CW'(5);
      AM_ZPX:  return CW'(6);
      AM_ABS:  return CW'(6);
      AM_ABSX: return CW'(7);
      default: return CW'(2);
    endcase
  endfunction
endpackage

// File: rtl/shr_decode.sv
module shr_decode
  import shr_pkg::*;
(
  input  logic [DW-1:0] opcode_i,
  output dec_t          dec_o
);
  always_comb begin
    dec_o = '{valid: 1'b1, rot: 1'b0, mode: AM_ACC};
    unique case (opcode_i)
      8'h4A: dec_o = '{valid: 1'b1, rot: 1'b0, mode: AM_ACC};
      8'h46: dec_o = '{valid: 1'b1, rot: 1'b0, mode: AM_ZP};
      8'h56: dec_o = '{valid: 1'b1, rot: 1'b0, mode: AM_ZPX};
      8'h4E: dec_o = '{valid: 1'b1, rot: 1'b0, mode: AM_ABS};
      8'h5E: dec_o = '{valid: 1'b1, rot: 1'b0, mode: AM_ABSX};
      8'h6A: dec_o = '{valid: 1'b1, rot: 1'b1, mode: AM_ACC};
      8'h66: dec_o = '{valid: 1'b1, rot: 1'b1, mode: AM_ZP};
      8'h76: dec_o = '{valid: 1'b1, rot: 1'b1, mode: AM_ZPX};
      8'h6E: dec_o = '{valid: 1'b1, rot: 1'b1, mode: AM_ABS};
      8'h7E: dec_o = '{valid: 1'b1, rot: 1'b1, mode: AM_ABSX};
      default: dec_o = '{valid: 1'b0, rot: 1'b0, mode: AM_ACC};
    endcase
  end
endmodule

// File: rtl/shr_agu.sv
module shr_agu
  import shr_pkg::*;
(
  input  amode_e        mode_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] x_i,
  output logic [AW-1:0] ea_o
);
  localparam int PW = AW - DW;

  logic [DW-1:0] zp_sum;
  logic [AW-1:0] abs_base;

  assign zp_sum   = lo_i + x_i;      // wraps inside page zero
  assign abs_base = {hi_i, lo_i};    // little-endian operand pair

  always_comb begin
    unique case (mode_i)
      AM_ZP:   ea_o = {{PW{1'b0}}, lo_i};
      AM_ZPX:  ea_o = {{PW{1'b0}}, zp_sum};
      AM_ABS:  ea_o = abs_base;
      AM_ABSX: ea_o = abs_base + AW'(x_i);
      default: ea_o = '0;
    endcase
  end
endmodule

// File: rtl/shr_alu.sv
module shr_alu
  import shr_pkg::*;
(
  input  logic [DW-1:0] src_i,
  input  logic          cin_i,
  input  logic          rot_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          n_o,
  output logic          z_o
);
  logic fill;

  assign fill  = rot_i & cin_i;
  assign res_o = {fill, src_i[DW-1:1]};
  assign c_o   = src_i[0];
  assign n_o   = res_o[DW-1];
  assign z_o   = (res_o == '0);
endmodule

// File: rtl/shr_exec.sv
module shr_exec
  import shr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] opcode_i,
  input  logic [DW-1:0] op_lo_i,
  input  logic [DW-1:0] op_hi_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] acc_i,
  input  logic          carry_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          illegal_o,
  output logic [DW-1:0] acc_o,
  output logic          acc_we_o,
  output logic          flag_c_o,
  output logic          flag_n_o,
  output logic          flag_z_o,
  output logic          flags_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_re_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam logic [CW-1:0] RD_CYC  = CW'(2);
  localparam logic [CW-1:0] CAP_CYC = CW'(3);

  dec_t          dec;
  logic [AW-1:0] ea;
  logic          accept;

  logic          busy_q, illegal_q, rot_q, mem_q, cin_q;
  logic [CW-1:0] cnt_q, last_q;
  logic [AW-1:0] ea_q;
  logic [DW-1:0] acc_q, data_q;

  logic [DW-1:0] src, res;
  logic          c_new, n_new, z_new;

  shr_decode u_dec (.opcode_i(opcode_i), .dec_o(dec));

  shr_agu u_agu (
    .mode_i(dec.mode), .lo_i(op_lo_i), .hi_i(op_hi_i), .x_i(x_i), .ea_o(ea)
  );

  assign accept = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      illegal_q <= 1'b0;
      rot_q     <= 1'b0;
      mem_q     <= 1'b0;
      cin_q     <= 1'b0;
      cnt_q     <= '0;
      last_q    <= '0;
      ea_q      <= '0;
      acc_q     <= '0;
      data_q    <= '0;
    end else begin
      illegal_q <= accept & ~dec.valid;
      if (accept && dec.valid) begin
        busy_q <= 1'b1;
        cnt_q  <= RD_CYC;
        last_q <= cycles_of(dec.mode);
        rot_q  <= dec.rot;
        mem_q  <= (dec.mode != AM_ACC);
        cin_q  <= carry_i;
        ea_q   <= ea;
        acc_q  <= acc_i;
      end else if (busy_q) begin
        cnt_q <= cnt_q + CW'(1);
        if (done_o) busy_q <= 1'b0;
        if (mem_q && cnt_q == CAP_CYC) data_q <= mem_rdata_i;
      end
    end
  end

  assign src = mem_q ? data_q : acc_q;

  shr_alu u_alu (
    .src_i(src), .cin_i(cin_q), .rot_i(rot_q),
    .res_o(res), .c_o(c_new), .n_o(n_new), .z_o(z_new)
  );

  assign busy_o      = busy_q;
  assign done_o      = busy_q && (cnt_q == last_q);
  assign illegal_o   = illegal_q;
  assign acc_o       = res;
  assign acc_we_o    = done_o & ~mem_q;
  assign flag_c_o    = c_new;
  assign flag_n_o    = n_new;
  assign flag_z_o    = z_new;
  assign flags_we_o  = done_o;
  assign mem_addr_o  = ea_q;
  assign mem_re_o    = busy_q & mem_q & (cnt_q == RD_CYC);
  assign mem_wdata_o = res;
  assign mem_we_o    = done_o & mem_q;
endmodule

// File: rtl/shr_exec_chk.sv
module shr_exec_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [7:0]  opcode_i,
  input logic        carry_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        illegal_o,
  input logic        acc_we_o,
  input logic        flag_n_o,
  input logic        flags_we_o,
  input logic [15:0] mem_addr_o,
  input logic        mem_re_o,
  input logic        mem_we_o
);
  logic [2:0]  cyc_q, exp_q;
  logic        lsr_q, cin_q, seen_re_q;
  logic [15:0] rd_addr_q;
  logic [2:0]  exp_cyc;

  always_comb begin
    case (opcode_i[4:2])
      3'b010:  exp_cyc = 3'd2;
      3'b001:  exp_cyc = 3'd5;
      3'b101:  exp_cyc = 3'd6;
      3'b011:  exp_cyc = 3'd6;
      default: exp_cyc = 3'd7;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0; exp_q <= '0; lsr_q <= 1'b0; cin_q <= 1'b0;
      seen_re_q <= 1'b0; rd_addr_q <= '0;
    end else begin
      if (start_i && !busy_o) begin
        cyc_q     <= 3'd2;
        exp_q     <= exp_cyc;
        lsr_q     <= ~opcode_i[5];
        cin_q     <= carry_i;
        seen_re_q <= 1'b0;
      end else if (busy_o) begin
        cyc_q <= cyc_q + 3'd1;
      end
      if (mem_re_o) begin
        seen_re_q <= 1'b1;
        rd_addr_q <= mem_addr_o;
      end
    end
  end

  a_r5_cycle_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cyc_q == exp_q);
  a_r6_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r6_busy_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r6_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r9_write_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> done_o && seen_re_q);
  a_r9_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o == rd_addr_q);
  a_r10_acc_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_o |-> !seen_re_q && !mem_we_o);
  a_r11_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !busy_o && !mem_we_o && !flags_we_o && !acc_we_o);
  a_r2_lsr_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_we_o && lsr_q) |-> !flag_n_o);
  a_r3_ror_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_we_o && !lsr_q) |-> flag_n_o == cin_q);
endmodule

bind shr_exec shr_exec_chk u_chk (.*);

// File: tb/shr_exec_tb_top.sv
module shr_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0, op_lo = '0, op_hi = '0, x = '0, acc = '0;
  logic        carry = 1'b0;
  logic        busy, done, illegal, acc_we, fc, fn, fz, flags_we, mem_re, mem_we;
  logic [7:0]  acc_out, mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem [4096];

  int n_chk = 0;
  int n_fail = 0;
  logic last_c = 1'b0;

  always #10ns clk = ~clk;

  shr_exec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .op_lo_i(op_lo), .op_hi_i(op_hi), .x_i(x), .acc_i(acc), .carry_i(carry),
    .busy_o(busy), .done_o(done), .illegal_o(illegal), .acc_o(acc_out),
    .acc_we_o(acc_we), .flag_c_o(fc), .flag_n_o(fn), .flag_z_o(fz),
    .flags_we_o(flags_we), .mem_addr_o(mem_addr), .mem_re_o(mem_re),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [7:0] op, lo, hi, xi, a,
                        input logic c, input int exp_n, input logic is_mem,
                        input logic [15:0] ea, input logic [7:0] exp_r,
                        input logic exp_c, input logic poke);
    int cyc, nre, nwe;
    logic got;
    logic [15:0] ra;
    nre = 0; nwe = 0; got = 1'b0; ra = '0;
    @(negedge clk);
    start = 1'b1; opcode = op; op_lo = lo; op_hi = hi; x = xi; acc = a; carry = c;
    cyc = 1;
    @(negedge clk);
    cyc = 2;
    while (!got && cyc <= 12) begin
      start = (poke && cyc == 3);
      opcode = (poke && cyc == 3) ? 8'h4A : op;
      check({tag, " R6 busy during run"}, busy, 1);
      if (mem_re) begin nre++; ra = mem_addr; end
      if (mem_we) nwe++;
      if (done) begin
        got = 1'b1;
        check({tag, " R5 done cycle"}, cyc, exp_n);
        check({tag, " R2/R3 result"}, is_mem ? mem_wdata : acc_out, exp_r);
        check({tag, " R4 carry"}, fc, exp_c);
        check({tag, " R4 negative"}, fn, exp_r[7]);
        check({tag, " R4 zero"}, fz, exp_r == 8'h00);
        check({tag, " R4 flag strobe"}, flags_we, 1);
        check({tag, " R10 acc strobe"}, acc_we, !is_mem);
        if (is_mem) check({tag, " R9 write addr"}, mem_addr, ea);
        last_c = fc;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    check({tag, " R5 done seen"}, got, 1);
    @(negedge clk);
    check({tag, " R6 busy low after"}, busy, 0);
    check({tag, " R13 no extra done"}, done, 0);
    check({tag, " R9 read count"}, nre, is_mem);
    check({tag, " R9 write count"}, nwe, is_mem);
    if (is_mem) begin
      check({tag, " R7/R8 read addr"}, ra, ea);
      check({tag, " R9 memory value"}, mem[ea[11:0]], exp_r);
    end
  endtask

  task automatic t_reset();
    check("R6 reset busy", busy, 0);
    check("R6 reset done", done, 0);
    check("R11 reset illegal", illegal, 0);
    check("R9 reset mem write", mem_we, 0);
  endtask

  task automatic t_acc();
    run_op("R3 ror acc 1", 8'h6A, 0, 0, 0, 8'h01, 0, 2, 0, 0, 8'h00, 1, 0);
    run_op("R2 lsr acc 81", 8'h4A, 0, 0, 0, 8'h81, 1, 2, 0, 0, 8'h40, 1, 0);
    run_op("R3 ror acc fill", 8'h6A, 0, 0, 0, 8'h00, 1, 2, 0, 0, 8'h80, 0, 0);
  endtask

  task automatic t_mem();
    mem[12'h010] = 8'hEE;
    run_op("R1 lsr zp", 8'h46, 8'h10, 8'h00, 0, 0, 1, 5, 1, 16'h0010, 8'h77, 0, 0);
    mem[12'h010] = 8'h03;
    run_op("R7 ror zpx wrap", 8'h76, 8'hF0, 8'h00, 8'h20, 0, 1, 6, 1, 16'h0010, 8'h81, 1, 0);
    mem[12'h234] = 8'h01;
    run_op("R8 lsr abs", 8'h4E, 8'h34, 8'h02, 0, 0, 0, 6, 1, 16'h0234, 8'h00, 1, 0);
    mem[12'h300] = 8'hFE;
    run_op("R8 ror absx cross", 8'h7E, 8'hFF, 8'h02, 8'h01, 0, 0, 7, 1, 16'h0300, 8'h7F, 0, 0);
    mem[12'h0A5] = 8'h9C;
    run_op("R1 ror zp", 8'h66, 8'hA5, 8'h00, 0, 0, 1, 5, 1, 16'h00A5, 8'hCE, 0, 0);
    mem[12'h121] = 8'h55;
    run_op("R1 lsr absx", 8'h5E, 8'h20, 8'h01, 8'h01, 0, 1, 7, 1, 16'h0121, 8'h2A, 1, 0);
  endtask

  task automatic t_illegal();
    mem[12'h010] = 8'h5A;
    @(negedge clk);
    start = 1'b1; opcode = 8'hEA; op_lo = 8'h10; op_hi = 8'h00;
    @(negedge clk);
    start = 1'b0;
    check("R11 illegal pulse", illegal, 1);
    check("R11 no busy", busy, 0);
    check("R11 no writes", {mem_we, acc_we, flags_we}, 0);
    @(negedge clk);
    check("R11 pulse ends", illegal, 0);
    check("R11 still idle", busy, 0);
    check("R11 memory kept", mem[12'h010], 8'h5A);
  endtask

  task automatic t_chain();
    mem[12'h041] = 8'h03;
    mem[12'h040] = 8'h01;
    run_op("R12 hi lsr", 8'h46, 8'h41, 0, 0, 0, 0, 5, 1, 16'h0041, 8'h01, 1, 0);
    run_op("R12 lo ror", 8'h66, 8'h40, 0, 0, 0, last_c, 5, 1, 16'h0040, 8'h80, 1, 0);
    check("R12 16-bit result", {mem[12'h041], mem[12'h040]}, 16'h0180);
  endtask

  task automatic t_busy_start();
    mem[12'h234] = 8'h02;
    run_op("R13 start while busy", 8'h4E, 8'h34, 8'h02, 0, 0, 0, 6, 1, 16'h0234, 8'h01, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_acc();
    t_mem();
    t_illegal();
    t_chain();
    t_busy_start();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule